// File: doc/BRIEF.md
# Processor Bus Address Decoder with Boot Vector Overlay

This block sits between a 24-bit processor bus and the memories and peripherals behind it. For each request it looks at the address, the access size (one, two or four bytes) and the direction. It then reports the destination: RAM, ROM, one of ten peripheral slots, or the low exception-vector area. An access that lands nowhere is reported as a fault. For every hit it also gives the byte offset that the selected target uses. For peripherals this offset is already adjusted for devices that sit on the odd byte lane. Data on the bus is big-endian, with the lowest address carrying the most significant byte, so the decoder passes the start address of an access through as the offset.

Four address windows are loaded at run time through a small configuration port: a read-only RAM range, a writable RAM range, a read-only ROM range, and a writable ROM data range that is physically stored in RAM. After reset every window is empty. A boot overlay is also active after reset. While it is active, the first two longword fetches, at addresses 0 and 4, are steered into ROM, and every other access is refused. The fetch at address 4 ends the overlay.

Top module: `bus_addr_decoder`

## Requirements
- R1: A synchronous active-high reset (`rst`) makes the boot overlay active and clears all four configurable windows to begin = end = 0, so that none of them can be hit.
- R2: While the overlay is active, a longword read (`req_size` = 2, `req_write` = 0) at address 0 gives target ROM (code 01) with offset 0. The same read at address 4 gives ROM with offset 4, and the overlay is inactive from the next clock edge on.
- R3: While the overlay is active, any other valid access gives a fault.
- R4: `req_size` 0, 1 and 2 mean 1, 2 and 4 bytes, and size 3 always faults. A configurable window or the vector area is hit only when begin <= addr and addr + bytes <= end, so the whole access must fit.
- R5: Outside the overlay, the checks run in this fixed order: RAM read-only window, RAM writable window, ROM read-only window, ROM data window, peripheral slots, vector area. The first match wins.
- R6: A write never hits the RAM read-only or ROM read-only window. It falls through to the later checks instead.
- R7: Target codes are RAM = 00, ROM = 01, peripheral = 10 and vector = 11. RAM windows, the ROM data window and the vector area (addr + bytes <= 0x400) give offset = addr. The ROM read-only window gives offset = addr - 0x100000. The ROM data window reports target RAM.
- R8: There are ten peripheral slots, each half-open [begin, end) and matched on the start address. Slot 0 is 0x180000-0x200000 and slot 1 is 0x200000-0x280000. Slots 2 to 9 are consecutive 0x4000-byte ranges from 0x3A0001 up to 0x3C0001. A hit on slot k sets only bit k of `periph_sel` and gives target 10.
- R9: The peripheral offset is (addr - begin) / 2 for a slot with an odd begin, and addr - begin for a slot with an even begin.
- R10: A valid access that matches nothing gives `hit_fault` = 1, with target 00, offset 0 and `periph_sel` 0. With `req_valid` low, all outputs are zero.
- R11: On a clock edge with `cfg_we` high, window `cfg_idx` takes `cfg_begin` and `cfg_end`. The index values are 0 = RAM read-only, 1 = RAM writable, 2 = ROM read-only and 3 = ROM data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = word, 2 = longword, 3 = invalid |
| req_addr | input | 24 | Byte start address |
| cfg_we | input | 1 | Window load strobe |
| cfg_idx | input | 2 | Window to load |
| cfg_begin | input | 24 | Inclusive lower bound |
| cfg_end | input | 24 | Exclusive upper bound |
| hit_target | output | 2 | Destination code |
| hit_fault | output | 1 | Access matched nothing or is not allowed |
| hit_offset | output | 24 | Offset within the destination |
| periph_sel | output | 10 | One-hot peripheral slot select |

## Verification
The decode outputs are combinational, so each result belongs to the request in the same cycle. The bench drives a request on the falling edge and samples two nanoseconds later, before the next rising edge can change anything. Two kinds of state move only on a rising edge: the overlay flag and the window registers. After a longword read at address 4, or after a configuration write or a reset, the bench therefore lets one rising edge pass before it checks the effect. It also checks the same access before that edge to show that nothing changed early.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    TGT_RAM    = 2'd0,
    TGT_ROM    = 2'd1,
    TGT_PERIPH = 2'd2,
    TGT_VECTOR = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  // Configurable window indices (R11)
  localparam int WIN_RAM_RO   = 0;
  localparam int WIN_RAM_RW   = 1;
  localparam int WIN_ROM_RO   = 2;
  localparam int WIN_ROM_DATA = 3;
  localparam int NUM_CFG_WIN  = 4;

  // R4: whole access must lie in [beg, lim)
  function automatic logic access_fits(input logic [ADDR_W-1:0] a,
                                       input logic [2:0]        nbytes,
                                       input logic [ADDR_W-1:0] beg,
                                       input logic [ADDR_W-1:0] lim);
    logic [ADDR_W:0] last_excl;
    last_excl = {1'b0, a} + {{(ADDR_W-2){1'b0}}, nbytes};
    return (a >= beg) && (last_excl <= {1'b0, lim});
  endfunction

endpackage

// File: rtl/busdec_window_bank.sv
module busdec_window_bank #(
  parameter int AW   = 24,
  parameter int NWIN = 4,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [IW-1:0]           cfg_idx,
  input  logic [AW-1:0]           cfg_begin,
  input  logic [AW-1:0]           cfg_end,
  output logic [NWIN-1:0][AW-1:0] win_beg,
  output logic [NWIN-1:0][AW-1:0] win_lim
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_beg[g] <= '0;
        win_lim[g] <= '0;
      end else if (cfg_we && (cfg_idx == IW'(g))) begin
        win_beg[g] <= cfg_begin;
        win_lim[g] <= cfg_end;
      end
    end
  end

  // R1: one cycle after reset every window is empty
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (win_beg == win_lim));

endmodule

// File: rtl/busdec_periph_match.sv
module busdec_periph_match #(
  parameter int          AW         = 24,
  parameter int          NBIG       = 2,
  parameter int unsigned BIG_BASE   = 32'h180000,
  parameter int unsigned BIG_SPAN   = 32'h080000,
  parameter int          NSMALL     = 8,
  parameter int unsigned SMALL_BASE = 32'h3A0001,
  parameter int unsigned SMALL_SPAN = 32'h004000,
  localparam int         NP         = NBIG + NSMALL
) (
  input  logic [AW-1:0] addr,
  output logic [NP-1:0] sel,
  output logic [AW-1:0] offset
);

  logic [NP-1:0]         hit;
  logic [NP-1:0][AW-1:0] slot_ofs;

  for (genvar g = 0; g < NP; g++) begin : g_slot
    localparam int unsigned BASE = (g < NBIG) ? BIG_BASE + g * BIG_SPAN
                                              : SMALL_BASE + (g - NBIG) * SMALL_SPAN;
    localparam int unsigned SPAN = (g < NBIG) ? BIG_SPAN : SMALL_SPAN;
    logic [AW:0]   lim;
    logic [AW-1:0] rel;
    assign lim    = (AW+1)'(BASE + SPAN);
    assign hit[g] = (addr >= AW'(BASE)) && ({1'b0, addr} < lim);
    assign rel    = addr - AW'(BASE);
    // R9: odd-based slots live on one byte lane, so the offset is halved
    if (BASE % 2 == 1) begin : g_odd
      assign slot_ofs[g] = rel >> 1;
    end else begin : g_even
      assign slot_ofs[g] = rel;
    end
  end

  always_comb begin
    sel    = '0;
    offset = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        offset = slot_ofs[i];
      end
    end
  end

  // R8: at most one slot is selected
  always_comb begin
    a_r8_slot_onehot: assert ($onehot0(sel) || $isunknown(addr));
  end

endmodule

// File: rtl/busdec_reset_overlay.sv
module busdec_reset_overlay #(
  parameter int AW = 24,
  parameter int unsigned SECOND_FETCH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  output logic          active,
  output logic          redirect
);
  import busdec_pkg::*;

  logic long_rd, at_first, at_second;

  assign long_rd   = req_valid && !req_write && (req_size == SZ_LONG);
  assign at_first  = (req_addr == '0);
  assign at_second = (req_addr == AW'(SECOND_FETCH));
  assign redirect  = active && long_rd && (at_first || at_second);

  always_ff @(posedge clk) begin
    if (rst)                               active <= 1'b1;
    else if (active && long_rd && at_second) active <= 1'b0;
  end

  // R2: the second vector fetch ends the overlay
  a_r2_second_fetch_clears: assert property (@(posedge clk) disable iff (rst)
    (active && long_rd && at_second) |=> !active);

  // R1: only reset brings the overlay back
  a_r1_overlay_sticky_off: assert property (@(posedge clk) disable iff (rst)
    !active |=> !active);

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
  parameter int          AW         = busdec_pkg::ADDR_W,
  parameter int unsigned ROM_BASE   = 32'h100000,
  parameter int unsigned VEC_LIMIT  = 32'h000400,
  parameter int          NBIG       = 2,
  parameter int unsigned BIG_BASE   = 32'h180000,
  parameter int unsigned BIG_SPAN   = 32'h080000,
  parameter int          NSMALL     = 8,
  parameter int unsigned SMALL_BASE = 32'h3A0001,
  parameter int unsigned SMALL_SPAN = 32'h004000,
  localparam int         NP         = NBIG + NSMALL,
  localparam int         NW         = busdec_pkg::NUM_CFG_WIN,
  localparam int         IW         = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_begin,
  input  logic [AW-1:0] cfg_end,
  output logic [1:0]    hit_target,
  output logic          hit_fault,
  output logic [AW-1:0] hit_offset,
  output logic [NP-1:0] periph_sel
);
  import busdec_pkg::*;

  logic [NW-1:0][AW-1:0] win_beg, win_lim;
  logic [NW-1:0]         win_fit;
  logic [NP-1:0]         p_sel;
  logic [AW-1:0]         p_ofs;
  logic                  ovl_active, ovl_redirect;
  logic [2:0]            nbytes;
  logic                  vec_fit;

  busdec_window_bank #(.AW(AW), .NWIN(NW)) u_windows (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_begin(cfg_begin), .cfg_end(cfg_end),
    .win_beg(win_beg), .win_lim(win_lim)
  );

  busdec_periph_match #(
    .AW(AW), .NBIG(NBIG), .BIG_BASE(BIG_BASE), .BIG_SPAN(BIG_SPAN),
    .NSMALL(NSMALL), .SMALL_BASE(SMALL_BASE), .SMALL_SPAN(SMALL_SPAN)
  ) u_periph (
    .addr(req_addr), .sel(p_sel), .offset(p_ofs)
  );

  busdec_reset_overlay #(.AW(AW)) u_overlay (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr),
    .active(ovl_active), .redirect(ovl_redirect)
  );

  assign nbytes = 3'd1 << req_size;

  for (genvar g = 0; g < NW; g++) begin : g_fit
    assign win_fit[g] = access_fits(req_addr, nbytes, win_beg[g], win_lim[g]);
  end
  assign vec_fit = access_fits(req_addr, nbytes, '0, AW'(VEC_LIMIT));

  // R5 priority chain; R6 read-only windows skipped on writes
  always_comb begin
    hit_target = TGT_RAM;
    hit_fault  = 1'b0;
    hit_offset = '0;
    periph_sel = '0;
    if (req_valid) begin
      if (ovl_active) begin
        if (ovl_redirect) begin
          hit_target = TGT_ROM;
          hit_offset = req_addr;
        end else begin
          hit_fault = 1'b1;
        end
      end else if (req_size == SZ_BAD) begin
        hit_fault = 1'b1;
      end else if (!req_write && win_fit[WIN_RAM_RO]) begin
        hit_target = TGT_RAM;
        hit_offset = req_addr;
      end else if (win_fit[WIN_RAM_RW]) begin
        hit_target = TGT_RAM;
        hit_offset = req_addr;
      end else if (!req_write && win_fit[WIN_ROM_RO]) begin
        hit_target = TGT_ROM;
        hit_offset = req_addr - AW'(ROM_BASE);
      end else if (win_fit[WIN_ROM_DATA]) begin
        hit_target = TGT_RAM;
        hit_offset = req_addr;
      end else if (|p_sel) begin
        hit_target = TGT_PERIPH;
        hit_offset = p_ofs;
        periph_sel = p_sel;
      end else if (vec_fit) begin
        hit_target = TGT_VECTOR;
        hit_offset = req_addr;
      end else begin
        hit_fault = 1'b1;
      end
    end
  end

  // R3: overlay refuses everything but the two vector fetches
  a_r3_overlay_refuses: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ovl_active && !ovl_redirect) |-> hit_fault);

  // R10: a fault carries no select and no offset
  a_r10_fault_clean: assert property (@(posedge clk) disable iff (rst)
    hit_fault |-> (periph_sel == '0 && hit_offset == '0 && hit_target == TGT_RAM));

  // R10: idle bus produces no fault and no select
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!hit_fault && periph_sel == '0));

  // R8: a select always comes with the peripheral target code
  a_r8_sel_target: assert property (@(posedge clk) disable iff (rst)
    (periph_sel != '0) |-> (hit_target == TGT_PERIPH && $onehot0(periph_sel)));

  // R6: a write never reports ROM
  a_r6_no_rom_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (hit_target != TGT_ROM));

endmodule

// File: tb/bus_addr_decoder_test.sv
`timescale 1ns/1ps
module bus_addr_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [23:0] cfg_begin = '0, cfg_end = '0;
  logic [1:0]  hit_target;
  logic        hit_fault;
  logic [23:0] hit_offset;
  logic [9:0]  periph_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_addr_decoder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_begin(cfg_begin), .cfg_end(cfg_end),
    .hit_target(hit_target), .hit_fault(hit_fault),
    .hit_offset(hit_offset), .periph_sel(periph_sel)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        wr;
    logic [1:0]  sz;
    logic [23:0] addr;
    logic        ef;
    logic [1:0]  et;
    logic [23:0] eo;
    logic [9:0]  es;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{"R7", 1'b0, 2'd2, 24'h002000, 1'b0, 2'd0, 24'h002000, 10'h000},
    '{"R4", 1'b0, 2'd2, 24'h07FFFC, 1'b0, 2'd0, 24'h07FFFC, 10'h000},
    '{"R4", 1'b0, 2'd2, 24'h07FFFD, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R4", 1'b0, 2'd0, 24'h07FFFF, 1'b0, 2'd0, 24'h07FFFF, 10'h000},
    '{"R7", 1'b0, 2'd1, 24'h100010, 1'b0, 2'd1, 24'h000010, 10'h000},
    '{"R6", 1'b1, 2'd1, 24'h100010, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R6", 1'b1, 2'd0, 24'h000180, 1'b0, 2'd3, 24'h000180, 10'h000},
    '{"R5", 1'b0, 2'd0, 24'h000180, 1'b0, 2'd0, 24'h000180, 10'h000},
    '{"R5", 1'b0, 2'd2, 24'h0001FC, 1'b0, 2'd0, 24'h0001FC, 10'h000},
    '{"R4", 1'b0, 2'd2, 24'h0001FD, 1'b0, 2'd3, 24'h0001FD, 10'h000},
    '{"R7", 1'b0, 2'd2, 24'h0003FC, 1'b0, 2'd3, 24'h0003FC, 10'h000},
    '{"R4", 1'b0, 2'd2, 24'h0003FD, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R7", 1'b1, 2'd2, 24'h095000, 1'b0, 2'd0, 24'h095000, 10'h000},
    '{"R8", 1'b0, 2'd1, 24'h180000, 1'b0, 2'd2, 24'h000000, 10'h001},
    '{"R9", 1'b0, 2'd0, 24'h27FFFF, 1'b0, 2'd2, 24'h07FFFF, 10'h002},
    '{"R8", 1'b0, 2'd0, 24'h3A0001, 1'b0, 2'd2, 24'h000000, 10'h004},
    '{"R9", 1'b0, 2'd0, 24'h3A0003, 1'b0, 2'd2, 24'h000001, 10'h004},
    '{"R8", 1'b0, 2'd0, 24'h3A4001, 1'b0, 2'd2, 24'h000000, 10'h008},
    '{"R9", 1'b0, 2'd0, 24'h3BFFFF, 1'b0, 2'd2, 24'h001FFF, 10'h200},
    '{"R8", 1'b0, 2'd0, 24'h3C0001, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R8", 1'b0, 2'd0, 24'h3A0000, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R9", 1'b1, 2'd0, 24'h3B0005, 1'b0, 2'd2, 24'h000002, 10'h040},
    '{"R4", 1'b0, 2'd3, 24'h002000, 1'b1, 2'd0, 24'h000000, 10'h000},
    '{"R10", 1'b0, 2'd2, 24'h120000, 1'b1, 2'd0, 24'h000000, 10'h000}
  };

  task automatic check(input string tag, input logic ef, input logic [1:0] et,
                       input logic [23:0] eo, input logic [9:0] es);
    checks++;
    if (hit_fault !== ef || hit_target !== et || hit_offset !== eo || periph_sel !== es) begin
      errors++;
      $display("FAIL %s addr=%h: got fault=%b tgt=%0d ofs=%h sel=%h, expected fault=%b tgt=%0d ofs=%h sel=%h",
               tag, req_addr, hit_fault, hit_target, hit_offset, periph_sel, ef, et, eo, es);
    end
  endtask

  // drive on the falling edge, sample 2 ns later (same request cycle)
  task automatic access(input logic wr, input logic [1:0] sz, input logic [23:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = a;
    #2;
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [23:0] b, input logic [23:0] e);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_idx   = idx;
    cfg_begin = b;
    cfg_end   = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R10 idle", 1'b0, 2'd0, 24'h0, 10'h0);

    // overlay phase
    access(1'b0, 2'd2, 24'h000000);
    check("R2 fetch0", 1'b0, 2'd1, 24'h000000, 10'h0);
    access(1'b0, 2'd0, 24'h000010);
    check("R3 byte", 1'b1, 2'd0, 24'h0, 10'h0);
    access(1'b1, 2'd2, 24'h000000);
    check("R3 write", 1'b1, 2'd0, 24'h0, 10'h0);
    access(1'b0, 2'd2, 24'h180000);
    check("R3 periph", 1'b1, 2'd0, 24'h0, 10'h0);
    access(1'b0, 2'd2, 24'h000004);
    check("R2 fetch4", 1'b0, 2'd1, 24'h000004, 10'h0);
    // after the edge the overlay is gone: address 0 is now vector area
    access(1'b0, 2'd2, 24'h000000);
    check("R2 cleared", 1'b0, 2'd3, 24'h000000, 10'h0);
    access(1'b0, 2'd2, 24'h002000);
    check("R1 empty win", 1'b1, 2'd0, 24'h0, 10'h0);

    // R11 window loads
    cfg(2'd0, 24'h000100, 24'h000200);
    cfg(2'd1, 24'h002000, 24'h080000);
    cfg(2'd2, 24'h100000, 24'h108000);
    cfg(2'd3, 24'h090000, 24'h0A0000);
    access(1'b0, 2'd1, 24'h100000);
    check("R11 rom win", 1'b0, 2'd1, 24'h000000, 10'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].sz, VECS[i].addr);
      check($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].ef, VECS[i].et, VECS[i].eo, VECS[i].es);
    end

    // R11: reload the writable RAM window as empty
    cfg(2'd1, 24'h000000, 24'h000000);
    access(1'b0, 2'd2, 24'h002000);
    check("R11 reload", 1'b1, 2'd0, 24'h0, 10'h0);

    // R1: reset mid-run restores overlay and empties windows
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, 2'd0, 24'h000180);
    check("R1 overlay back", 1'b1, 2'd0, 24'h0, 10'h0);
    access(1'b0, 2'd2, 24'h000000);
    check("R1 fetch0", 1'b0, 2'd1, 24'h000000, 10'h0);
    access(1'b0, 2'd2, 24'h000004);
    check("R1 fetch4", 1'b0, 2'd1, 24'h000004, 10'h0);
    access(1'b0, 2'd2, 24'h0001FC);
    check("R1 win cleared", 1'b0, 2'd3, 24'h0001FC, 10'h0);
    access(1'b0, 2'd1, 24'h100010);
    check("R1 rom win cleared", 1'b1, 2'd0, 24'h0, 10'h0);

    @(negedge clk);
    req_valid = 1'b0;
    #2;
    check("R10 idle end", 1'b0, 2'd0, 24'h0, 10'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule